// File: doc/BRIEF.md
# SPI Cipher Buffer Exchange Front End

This block is an SPI slave that sits in front of a 16-byte data buffer shared with a block-cipher engine. The host clocks new input bytes into the buffer. In the same chip-select burst it clocks out the results of the previous cipher run, one byte behind its writes. This lets back-to-back cipher runs be streamed with one burst per run. A final byte written to the control mirror location can launch the next run. One extra burst after the last run retrieves that run's results.

The serial pins are oversampled in the system clock domain through two-flop synchronizers. Every burst opens with a command byte, during which the slave returns a status byte. A start-address byte follows, then data bytes at auto-incrementing addresses. The engine is reached through a single-cycle start strobe, a flattened copy of the buffer, a mode field, a done pulse and a flattened result word. On done, the result word is loaded into the buffer.

Top module: `spi_fast_xchg`

## Requirements
- R1: During the first byte of each burst the slave returns a status byte, MSB first: bit 7 = engine busy, bit 1 = sticky start error, bit 0 = done; after reset all are 0 and `miso` is 0.
- R2: The second byte of a burst is the start address; each following data byte goes to the current address, which then increments by one. Addresses 0x84..0x93 are buffer bytes 0..15 (byte i on `engData[8i+7:8i]`), 0x83 is the control register and 0x94 mirrors it.
- R3: SPI mode 0 (sample on SCLK rise, shift on fall). `miso` is 0x00 during the address byte and the first data byte. During each later data byte it carries the value that the location addressed by the preceding data byte held before that byte was written.
- R4: A data byte written to a buffer location replaces whatever that location held, including a previous result.
- R5: A data byte written to 0x94 with bit 7 set, while the engine is idle, gives exactly one single-cycle `engStart` pulse. The buffer content is then on `engData`. Writes to 0x83 or 0x94 store bits 6:0 to `engMode`; bit 7 written to 0x83 starts nothing.
- R6: `engDone` while busy loads all result bytes into the buffer, clears busy and sets done; done clears on the next accepted start.
- R7: While the engine is busy, reads of buffer locations return 0x00.
- R8: A start request while busy is ignored (no `engStart`) and sets the error bit, which stays set until reset.
- R9: Raising chip select in the middle of a byte discards that partial byte; no location changes for it.
- R10: Addresses outside 0x83..0x94 ignore writes and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock from the host, idle low |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| engStart | output | 1 | One-cycle start strobe to the cipher engine |
| engMode | output | 7 | Mode bits from the control register |
| engData | output | 128 | Buffer content, byte i at bits 8i+7:8i |
| engDone | input | 1 | One-cycle completion pulse from the engine |
| engResult | input | 128 | Engine result, byte i at bits 8i+7:8i |

## Verification
A wrong address counter or a misplaced read capture shows up at once on `miso`. The byte that comes back would belong to the wrong location or sit at the wrong lag, within the same burst. A stale busy, done or error flag shows up in the status byte of the very next burst. A missed or doubled start shows up at the engine interface one cycle after the control byte completes. A buffer that the result load or a partial byte corrupts is exposed by the next read-back burst over the same addresses.

// File: rtl/fbx_pkg.sv
`timescale 1ns/1ps
package fbx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DATA
  } fbxPhase_e;

  // strobes and levels the control side hands to the datapath
  typedef struct packed {
    logic latchAddr;   // address byte complete
    logic xferData;    // data byte complete: capture read, write, increment
    logic hideBuf;     // engine busy: buffer reads return zero
    logic loadResult;  // engine finished: load result word
  } fbxStrobe_t;

endpackage

// File: rtl/fbx_control.sv
`timescale 1ns/1ps
module fbx_control import fbx_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       byteDone,
  input  logic       ctrlHit,
  input  logic       startBit,
  input  logic       engDone,
  output fbxStrobe_t strobe,
  output logic [7:0] statusByte,
  output logic       engStart
);

  fbxPhase_e phase;
  logic busy;
  logic doneFlag;
  logic errFlag;
  logic startReq;

  assign startReq = byteDone && (phase == PH_DATA) && ctrlHit && startBit;

  always_comb begin
    strobe.latchAddr  = byteDone && (phase == PH_ADDR);
    strobe.xferData   = byteDone && (phase == PH_DATA);
    strobe.hideBuf    = busy;
    strobe.loadResult = engDone && busy;
  end

  assign statusByte = {busy, 5'b00000, errFlag, doneFlag};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
    end else if (csRise) begin
      phase <= PH_IDLE;
    end else if (csFall) begin
      phase <= PH_CMD;
    end else if (byteDone) begin
      case (phase)
        PH_CMD:  phase <= PH_ADDR;
        PH_ADDR: phase <= PH_DATA;
        default: phase <= phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      engStart <= 1'b0;
    end else begin
      engStart <= 1'b0;
      if (startReq) begin
        if (busy) begin
          errFlag <= 1'b1;
        end else begin
          engStart <= 1'b1;
          busy     <= 1'b1;
          doneFlag <= 1'b0;
        end
      end
      if (engDone && busy) begin
        busy     <= 1'b0;
        doneFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbx_datapath.sv
`timescale 1ns/1ps
module fbx_datapath import fbx_pkg::*; #(
  parameter int          NUM_BYTES   = 16,
  parameter logic [7:0]  BUF_BASE    = 8'h84,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclk,
  input  logic                   csN,
  input  logic                   mosi,
  output logic                   miso,
  input  fbxStrobe_t             strobe,
  input  logic [7:0]             statusByte,
  output logic                   csFall,
  output logic                   csRise,
  output logic                   byteDone,
  output logic                   ctrlHit,
  output logic                   startBit,
  output logic [6:0]             cfgReg,
  output logic [8*NUM_BYTES-1:0] bufFlat,
  input  logic [8*NUM_BYTES-1:0] resultFlat
);

  localparam int         IDX_W     = $clog2(NUM_BYTES);
  localparam logic [7:0] BUF_TOP   = 8'(int'(BUF_BASE) + NUM_BYTES - 1);
  localparam logic [7:0] CFG_ADDR  = 8'(int'(BUF_BASE) - 1);
  localparam logic [7:0] CTRL_ADDR = 8'(int'(BUF_BASE) + NUM_BYTES);

  // pin synchronizers
  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic sclkS, csS, mosiS, sclkPrev, csPrev;
  logic sclkRise, sclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign csS      = csPipe[SYNC_STAGES-1];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];
  assign sclkRise = sclkS && !sclkPrev && !csS;
  assign sclkFall = !sclkS && sclkPrev && !csS;
  assign csFall   = !csS && csPrev;
  assign csRise   = csS && !csPrev;

  // serial framing
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic [7:0] rxByte;
  logic [7:0] txShift;
  logic [7:0] txNext;
  logic [7:0] curAddr;
  logic [7:0] readVal;

  assign rxByte   = {rxShift, mosiS};
  assign byteDone = sclkRise && (bitCnt == 3'd7);
  assign miso     = txShift[7];
  assign startBit = rxByte[7];

  // address decode
  logic             inBuf;
  logic             inCtrl;
  logic [IDX_W-1:0] bufIdx;
  logic [7:0]       bufMem [NUM_BYTES];

  assign inBuf   = (curAddr >= BUF_BASE) && (curAddr <= BUF_TOP);
  assign inCtrl  = (curAddr == CFG_ADDR) || (curAddr == CTRL_ADDR);
  assign ctrlHit = (curAddr == CTRL_ADDR);
  assign bufIdx  = IDX_W'(curAddr - BUF_BASE);

  always_comb begin
    if (inBuf) begin
      readVal = strobe.hideBuf ? 8'h00 : bufMem[bufIdx];
    end else if (inCtrl) begin
      readVal = {1'b0, cfgReg};
    end else begin
      readVal = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      txNext  <= '0;
      curAddr <= '0;
    end else begin
      if (csS) begin
        bitCnt <= '0;
      end else if (sclkRise) begin
        bitCnt  <= bitCnt + 3'd1;
        rxShift <= {rxShift[5:0], mosiS};
      end

      if (csFall) begin
        txShift <= statusByte;
      end else if (sclkFall) begin
        txShift <= (bitCnt == 3'd0) ? txNext : {txShift[6:0], 1'b0};
      end

      if (csFall) begin
        txNext <= 8'h00;
      end else if (byteDone) begin
        txNext <= strobe.xferData ? readVal : 8'h00;
      end

      if (strobe.latchAddr) begin
        curAddr <= rxByte;
      end else if (strobe.xferData) begin
        curAddr <= curAddr + 8'd1;
      end
    end
  end

  // buffer and control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        bufMem[i] <= 8'h00;
      end
      cfgReg <= '0;
    end else begin
      if (strobe.loadResult) begin
        for (int i = 0; i < NUM_BYTES; i++) begin
          bufMem[i] <= resultFlat[8*i +: 8];
        end
      end
      if (strobe.xferData && inBuf) begin
        bufMem[bufIdx] <= rxByte;
      end
      if (strobe.xferData && inCtrl) begin
        cfgReg <= rxByte[6:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_flat
    assign bufFlat[8*g +: 8] = bufMem[g];
  end

endmodule

// File: rtl/spi_fast_xchg.sv
`timescale 1ns/1ps
module spi_fast_xchg import fbx_pkg::*; #(
  parameter int         NUM_BYTES   = 16,
  parameter logic [7:0] BUF_BASE    = 8'h84,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclk,
  input  logic                   csN,
  input  logic                   mosi,
  output logic                   miso,
  output logic                   engStart,
  output logic [6:0]             engMode,
  output logic [8*NUM_BYTES-1:0] engData,
  input  logic                   engDone,
  input  logic [8*NUM_BYTES-1:0] engResult
);

  fbxStrobe_t strobe;
  logic [7:0] statusByte;
  logic       csFall, csRise, byteDone, ctrlHit, startBit;

  fbx_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csFall     (csFall),
    .csRise     (csRise),
    .byteDone   (byteDone),
    .ctrlHit    (ctrlHit),
    .startBit   (startBit),
    .engDone    (engDone),
    .strobe     (strobe),
    .statusByte (statusByte),
    .engStart   (engStart)
  );

  fbx_datapath #(
    .NUM_BYTES   (NUM_BYTES),
    .BUF_BASE    (BUF_BASE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sclk       (sclk),
    .csN        (csN),
    .mosi       (mosi),
    .miso       (miso),
    .strobe     (strobe),
    .statusByte (statusByte),
    .csFall     (csFall),
    .csRise     (csRise),
    .byteDone   (byteDone),
    .ctrlHit    (ctrlHit),
    .startBit   (startBit),
    .cfgReg     (engMode),
    .bufFlat    (engData),
    .resultFlat (engResult)
  );

endmodule

// File: rtl/spi_fast_xchg_chk.sv
`timescale 1ns/1ps
module spi_fast_xchg_chk #(
  parameter int NUM_BYTES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   engStart,
  input logic                   engDone,
  input logic [8*NUM_BYTES-1:0] engData,
  input logic [8*NUM_BYTES-1:0] engResult,
  input logic [7:0]             statusByte,
  input logic                   xferData
);

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  p_start_needs_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !$past(statusByte[7]));

  p_start_sets_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (statusByte[7] && !statusByte[0]));

  p_done_clears_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && statusByte[7]) |=> (!statusByte[7] && statusByte[0]));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[1] |=> statusByte[1]);

  p_result_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && statusByte[7] && !xferData) |=> (engData == $past(engResult)));

endmodule

bind spi_fast_xchg spi_fast_xchg_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .engStart   (engStart),
  .engDone    (engDone),
  .engData    (engData),
  .engResult  (engResult),
  .statusByte (statusByte),
  .xferData   (strobe.xferData)
);

// File: tb/spi_fast_xchg_tb.sv
`timescale 1ns/1ps
module spi_fast_xchg_tb;

  localparam int HALF = 8;
  localparam int LAT  = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic engStart;
  logic [6:0] engMode;
  logic [127:0] engData;
  logic engDone = 1'b0;
  logic [127:0] engLatched = '0;
  logic [127:0] engResult;
  int engCnt = 0;
  int startSeen = 0;

  int total = 0;
  int fails = 0;

  logic [7:0] txq [0:23];
  logic [7:0] rxq [0:23];
  logic [7:0] expq [0:23];
  logic [7:0] mBuf [0:15];
  logic [7:0] mSnap [0:15];
  logic [6:0] mCfg = '0;
  bit mBusy = 0, mDone = 0, mErr = 0, mStartReq = 0;
  int mStarts = 0;

  always #2.5 clk = ~clk;

  spi_fast_xchg u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .engStart(engStart), .engMode(engMode), .engData(engData),
    .engDone(engDone), .engResult(engResult)
  );

  function automatic logic [7:0] keyByte(int i);
    return 8'(8'h3C + 7 * i);
  endfunction

  function automatic logic [127:0] xform(logic [127:0] d);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = d[8*i +: 8] ^ keyByte(i);
    return r;
  endfunction

  assign engResult = xform(engLatched);

  // simple engine stand-in
  always @(posedge clk) begin
    engDone <= 1'b0;
    if (engStart) begin
      engLatched <= engData;
      engCnt     <= LAT;
      startSeen  <= startSeen + 1;
    end else if (engCnt > 0) begin
      engCnt <= engCnt - 1;
      if (engCnt == 1) engDone <= 1'b1;
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(logic [7:0] a);
    int idx = int'(a) - 'h84;
    if (a >= 8'h84 && a <= 8'h93) return mBusy ? 8'h00 : mBuf[idx];
    if (a == 8'h83 || a == 8'h94) return {1'b0, mCfg};
    return 8'h00;
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] v);
    int idx = int'(a) - 'h84;
    if (a >= 8'h84 && a <= 8'h93) mBuf[idx] = v;
    if (a == 8'h83 || a == 8'h94) mCfg = v[6:0];
    if (a == 8'h94 && v[7]) mStartReq = 1;
  endtask

  function automatic logic [127:0] packSnap();
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = mSnap[i];
    return r;
  endfunction

  task automatic runBurst(input int nBytes, input int extraBits);
    int totalBits = nBytes * 8 + extraBits;
    @(negedge clk); csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < totalBits; k++) begin
      mosi = txq[k/8][7-(k%8)];
      repeat (HALF) @(negedge clk);
      rxq[k/8][7-(k%8)] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk); csN = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  // predicts, runs and checks one burst; tag names the data-byte requirement
  task automatic doBurst(input int nBytes, input string tag, input int extraBits);
    logic [7:0] a;
    logic [7:0] rd;
    expq[0] = {mBusy, 5'b00000, mErr, mDone};
    expq[1] = 8'h00;
    mStartReq = 0;
    a = txq[1];
    rd = 8'h00;
    for (int k = 2; k < nBytes; k++) begin
      expq[k] = (k == 2) ? 8'h00 : rd;
      rd = modelRead(a);
      modelWrite(a, txq[k]);
      a = a + 8'd1;
    end
    runBurst(nBytes, extraBits);
    check("R1 status byte", rxq[0], expq[0]);
    for (int k = 1; k < nBytes; k++) begin
      if (k < 3) check("R3 leading zero byte", rxq[k], expq[k]);
      else check(tag, rxq[k], expq[k]);
    end
    if (mStartReq) begin
      if (!mBusy) begin
        mBusy = 1; mDone = 0; mStarts++;
        for (int i = 0; i < 16; i++) mSnap[i] = mBuf[i];
      end else begin
        mErr = 1;
      end
    end
  endtask

  task automatic finishEngine();
    repeat (LAT + 200) @(negedge clk);
    for (int i = 0; i < 16; i++) mBuf[i] = mSnap[i] ^ keyByte(i);
    mBusy = 0; mDone = 1;
  endtask

  task automatic header(input logic [7:0] a);
    txq[0] = 8'h83;
    txq[1] = a;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mBuf[i] = 8'h00; mSnap[i] = 8'h00; end
    for (int i = 0; i < 24; i++) begin txq[i] = 8'h00; rxq[i] = 8'h00; expq[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 reset miso", miso, 1'b0);
    check("R1 reset engStart", engStart, 1'b0);
    check("R2 reset buffer", engData, 128'h0);

    // run A: config + plaintext + start through the mirror (R2, R3, R5)
    header(8'h83); txq[2] = 8'h03;
    for (int i = 0; i < 16; i++) txq[3+i] = 8'(i * 17 + 1);
    txq[19] = 8'h83;
    doBurst(20, "R3 lagged read", 0);
    check("R5 one start", startSeen, mStarts);
    check("R5 engine data", engData, packSnap());
    check("R5 engine mode", engMode, mCfg);
    check("R2 byte order", engData[15:8], 8'd18);

    // status while busy (R1)
    header(8'h00); doBurst(1, "R1", 0);
    finishEngine();
    header(8'h00); doBurst(1, "R6 done status", 0);

    // run B: read results of A while writing new input (R6, R3)
    header(8'h83); txq[2] = 8'h05;
    for (int i = 0; i < 16; i++) txq[3+i] = 8'(8'hA0 + 3 * i);
    txq[19] = 8'h85;
    doBurst(20, "R6 result readback", 0);
    check("R6 start count", startSeen, mStarts);

    // burst during busy: buffer reads hidden (R7)
    header(8'h83); txq[2] = 8'h05;
    for (int i = 0; i < 16; i++) txq[3+i] = 8'hFF;
    txq[19] = 8'h05;
    doBurst(20, "R7 hidden while busy", 0);
    check("R7 no extra start", startSeen, mStarts);
    finishEngine();

    // overwrite and read back (R3, R4)
    header(8'h84);
    for (int i = 0; i < 16; i++) txq[2+i] = 8'(8'h40 + i);
    doBurst(18, "R3 results of B", 0);
    header(8'h84);
    for (int i = 0; i < 16; i++) txq[2+i] = 8'h00;
    doBurst(18, "R4 overwrite readback", 0);

    // partial trailing byte (R9)
    header(8'h88); txq[2] = 8'h5A; txq[3] = 8'hC3;
    doBurst(3, "R9 partial burst", 5);
    header(8'h88);
    for (int i = 0; i < 4; i++) txq[2+i] = 8'h11;
    doBurst(6, "R9 partial discarded", 0);

    // outside window and start bit at 0x83 (R10, R5)
    header(8'h95);
    for (int i = 0; i < 4; i++) txq[2+i] = 8'hEE;
    doBurst(6, "R10 outside reads zero", 0);
    header(8'h80);
    txq[2] = 8'h77; txq[3] = 8'h66; txq[4] = 8'h55; txq[5] = 8'h87; txq[6] = 8'h22;
    doBurst(7, "R10 low addresses", 0);
    header(8'h80);
    for (int i = 0; i < 5; i++) txq[2+i] = 8'h00;
    txq[5] = 8'h07;
    doBurst(7, "R10 writes ignored", 0);
    check("R5 no start from 0x83", startSeen, mStarts);
    check("R5 mode bits", engMode, mCfg);

    // start, then start while busy (R5, R8)
    header(8'h94); txq[2] = 8'h81;
    doBurst(3, "R5 mirror start", 0);
    check("R5 start accepted", startSeen, mStarts);
    header(8'h94); txq[2] = 8'h80;
    doBurst(3, "R8 busy start", 0);
    check("R8 busy start ignored", startSeen, mStarts);
    header(8'h00); doBurst(1, "R8", 0);
    finishEngine();
    header(8'h00); doBurst(1, "R8", 0);
    check("R8 error sticky", mErr, 1'b1);

    summary();
  end

endmodule